// File: doc/BRIEF.md
# Two-Wire Converter Slave Front End

This block is the bus-facing half of a small analog-to-digital converter. It watches an oversampled two-wire bus (clock line and data line, both open-drain), finds start, repeated start and stop conditions, and answers a fixed 7-bit address. In a write session, every data byte is steered by its top bit into one of two registers. One register holds the converter setup: reference selection, clock source and polarity. The other holds the conversion configuration: scan mode, channel selection and input type. The decoded fields leave the block as plain outputs for the conversion logic.

The block also recognises the high-speed master code. It refuses that byte with a not-acknowledge and then reports high-speed operation until the next stop. When an address match starts a read or a write, the block emits a single-cycle strobe so that a downstream conversion sequencer can begin its work. In a read session the block acknowledges the address and then lets go of the data line. Shifting out results is left to that sequencer.

Both lines pass through a two-flop synchroniser. The system clock must therefore run at least eight times faster than the bus clock.

Top module: `adc_twowire_slave`

## Requirements
- R1: After reset the outputs are as follows: reference select 000, external clock 0, bipolar 0, scan 00, channel select 0, single-ended 1, high-speed mode 0, and the data line is not pulled low.
- R2: An address byte whose upper seven bits are 0110110 is acknowledged. The block pulls the data line low for the whole ninth clock pulse. When the lowest bit of that byte is 0 (write, byte 0x6C), `wr_go` pulses.
- R3: When an address byte does not match, it is not acknowledged. Every following byte is ignored, with no acknowledge and no register change, until the next start or repeated start.
- R4: In a write session each data byte is acknowledged. A byte with bit 7 = 1 loads the setup fields: bits 6:4 go to the reference select, bit 3 to the external clock and bit 2 to bipolar. A byte with bit 7 = 0 loads the configuration fields: bits 6:5 go to scan, bit 1 to channel select and bit 0 to single-ended. Either order and either count (one or two bytes) works.
- R5: A setup byte with bit 1 = 0 still loads its setup fields, and it also returns the configuration fields to their reset values (scan 00, channel 0, single-ended 1). A setup byte with bit 1 = 1 leaves the configuration fields untouched.
- R6: When the first byte after a start has the form 0000_1xxx, it is answered with a not-acknowledge, meaning the data line is left high during the ninth pulse. After that ninth pulse, high-speed mode reads 1.
- R7: A stop condition, meaning the data line rises while the clock line is high, clears high-speed mode.
- R8: The read address 0x6D is acknowledged and pulses `rd_go`. After that, the block releases the data line and ignores the bus until the next start.
- R9: A repeated start, meaning the data line falls while the clock line is high in the middle of a session, restarts address reception and leaves high-speed mode unchanged.
- R10: `rd_go` and `wr_go` each pulse for exactly one system clock per matching address byte, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain drive) |
| ref_sel | output | 3 | Reference selection field |
| ext_clk | output | 1 | 1 selects external conversion clock |
| bipolar | output | 1 | 1 selects bipolar coding |
| scan_mode | output | 2 | Scan mode field |
| chan_sel | output | 1 | Channel select field |
| single_ended | output | 1 | 1 single-ended inputs, 0 differential |
| hs_mode | output | 1 | 1 while the bus is in high-speed mode |
| rd_go | output | 1 | One-cycle strobe on a matched read address |
| wr_go | output | 1 | One-cycle strobe on a matched write address |

## Verification
The hardest case to reach is the move into high-speed mode. It needs a master code right after a start and a not-acknowledge, and then a repeated start that must keep the mode while address reception starts again. The bench builds that exact sequence from bit-level bus tasks. It checks that the ninth pulse stays high, that the mode holds across the repeated start and an acknowledged write, and that only the final stop clears it. A second case that is hard to provoke is a byte that arrives after a wrong address. The bench sends a valid configuration byte after a mismatch and confirms that no acknowledge appears and that the configuration outputs do not change.

// File: rtl/adc_twowire_slave.sv
module adc_twowire_slave #(
  parameter logic [6:0] SLAVE_ADDR = 7'b0110110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic [2:0] ref_sel,
  output logic       ext_clk,
  output logic       bipolar,
  output logic [1:0] scan_mode,
  output logic       chan_sel,
  output logic       single_ended,
  output logic       hs_mode,
  output logic       rd_go,
  output logic       wr_go
);

  typedef enum logic [1:0] {S_IDLE, S_RX, S_ACK} state_t;

  logic [2:0] scl_sy, sda_sy;
  logic       scl_s, scl_q, sda_s, sda_q;
  logic       scl_rise, scl_fall, start_det, stop_det;
  state_t     state;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic [7:0] rx_byte;
  logic       first, ack_en, cont, hs_pend, ack_phase;

  assign scl_s = scl_sy[1];
  assign scl_q = scl_sy[2];
  assign sda_s = sda_sy[1];
  assign sda_q = sda_sy[2];
  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  =  scl_s & scl_q & ~sda_q & sda_s;
  assign rx_byte   = {shreg, sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_in};
      sda_sy <= {sda_sy[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      bit_cnt <= '0;
      shreg <= '0;
      first <= 1'b0;
      ack_en <= 1'b0;
      cont <= 1'b0;
      hs_pend <= 1'b0;
      ack_phase <= 1'b0;
      sda_pull <= 1'b0;
      ref_sel <= '0;
      ext_clk <= 1'b0;
      bipolar <= 1'b0;
      scan_mode <= '0;
      chan_sel <= 1'b0;
      single_ended <= 1'b1;
      hs_mode <= 1'b0;
      rd_go <= 1'b0;
      wr_go <= 1'b0;
    end else begin
      rd_go <= 1'b0;
      wr_go <= 1'b0;
      if (start_det) begin
        state <= S_RX;
        bit_cnt <= '0;
        first <= 1'b1;
        hs_pend <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state <= S_IDLE;
        hs_mode <= 1'b0;
        hs_pend <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          S_RX: if (scl_rise) begin
            shreg <= rx_byte[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              ack_phase <= 1'b0;
              state <= S_ACK;
              if (first) begin
                if (rx_byte[7:1] == SLAVE_ADDR) begin
                  ack_en <= 1'b1;
                  cont <= ~rx_byte[0];
                  rd_go <= rx_byte[0];
                  wr_go <= ~rx_byte[0];
                end else if (rx_byte[7:3] == 5'b00001) begin
                  ack_en <= 1'b0;
                  cont <= 1'b0;
                  hs_pend <= 1'b1;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                ack_en <= 1'b1;
                cont <= 1'b1;
                if (rx_byte[7]) begin
                  ref_sel <= rx_byte[6:4];
                  ext_clk <= rx_byte[3];
                  bipolar <= rx_byte[2];
                  if (!rx_byte[1]) begin
                    scan_mode <= 2'b00;
                    chan_sel <= 1'b0;
                    single_ended <= 1'b1;
                  end
                end else begin
                  scan_mode <= rx_byte[6:5];
                  chan_sel <= rx_byte[1];
                  single_ended <= rx_byte[0];
                end
              end
            end
          end
          S_ACK: if (scl_fall) begin
            if (!ack_phase) begin
              ack_phase <= 1'b1;
              sda_pull <= ack_en;
            end else begin
              sda_pull <= 1'b0;
              bit_cnt <= '0;
              first <= 1'b0;
              state <= cont ? S_RX : S_IDLE;
              if (hs_pend) begin
                hs_mode <= 1'b1;
                hs_pend <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_drive_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);
  p_hs_after_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> $past(!sda_pull));
  p_stop_leaves_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs_mode);
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_go && wr_go));
  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go || wr_go) |=> !(rd_go || wr_go));

endmodule

// File: tb/adc_twowire_slave_test.sv
module adc_twowire_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_pull, ext_clk, bipolar, chan_sel, single_ended, hs_mode, rd_go, wr_go;
  logic [2:0] ref_sel;
  logic [1:0] scan_mode;
  int n_chk = 0, n_bad = 0, rd_cnt = 0, wr_cnt = 0;
  localparam int Q = 10;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  adc_twowire_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_pull(sda_pull),
    .ref_sel(ref_sel), .ext_clk(ext_clk), .bipolar(bipolar), .scan_mode(scan_mode),
    .chan_sel(chan_sel), .single_ended(single_ended), .hs_mode(hs_mode),
    .rd_go(rd_go), .wr_go(wr_go));

  always @(posedge clk) begin
    if (rd_go) rd_cnt <= rd_cnt + 1;
    if (wr_go) wr_cnt <= wr_cnt + 1;
  end

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic qw(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bus_start;
    sda_m = 1; scl = 1; qw(Q);
    sda_m = 0; qw(Q);
    scl = 0; qw(Q);
  endtask

  task automatic bus_rstart;
    sda_m = 1; qw(Q);
    scl = 1; qw(Q);
    sda_m = 0; qw(Q);
    scl = 0; qw(Q);
  endtask

  task automatic bus_stop;
    sda_m = 0; qw(Q);
    scl = 1; qw(Q);
    sda_m = 1; qw(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(Q);
      scl = 1; qw(2*Q);
      scl = 0; qw(Q);
    end
    sda_m = 1; qw(Q);
    scl = 1; qw(Q);
    acked = ~sda_bus;
    qw(Q);
    scl = 0; qw(Q);
  endtask

  task automatic t_reset;
    chk("R1 ref_sel", ref_sel, 0);
    chk("R1 ext_clk", ext_clk, 0);
    chk("R1 bipolar", bipolar, 0);
    chk("R1 scan", scan_mode, 0);
    chk("R1 chan", chan_sel, 0);
    chk("R1 single", single_ended, 1);
    chk("R1 hs", hs_mode, 0);
    chk("R1 sda_pull", sda_pull, 0);
  endtask

  task automatic t_write_both_orders;
    logic a;
    int w0;
    w0 = wr_cnt;
    bus_start;
    send_byte(8'h6C, a); chk("R2 addr ack", a, 1);
    chk("R10 one wr pulse", wr_cnt - w0, 1);
    chk("R10 no rd pulse", rd_cnt, 0);
    send_byte(8'hB6, a); chk("R4 setup ack", a, 1);
    send_byte(8'h42, a); chk("R4 cfg ack", a, 1);
    bus_stop;
    chk("R4 ref_sel", ref_sel, 3);
    chk("R4 ext_clk", ext_clk, 0);
    chk("R4 bipolar", bipolar, 1);
    chk("R4 scan", scan_mode, 2);
    chk("R4 chan", chan_sel, 1);
    chk("R4 single", single_ended, 0);
    bus_start;
    send_byte(8'h6C, a); chk("R2 addr ack 2", a, 1);
    send_byte(8'h20, a); chk("R4 cfg first ack", a, 1);
    send_byte(8'hCA, a); chk("R4 setup second ack", a, 1);
    bus_stop;
    chk("R4 scan rev", scan_mode, 1);
    chk("R4 chan rev", chan_sel, 0);
    chk("R4 single rev", single_ended, 0);
    chk("R4 ref_sel rev", ref_sel, 4);
    chk("R4 ext_clk rev", ext_clk, 1);
    chk("R4 bipolar rev", bipolar, 0);
    chk("R10 two wr pulses", wr_cnt - w0, 2);
  endtask

  task automatic t_cfg_reset;
    logic a;
    bus_start;
    send_byte(8'h6C, a);
    send_byte(8'h63, a);
    bus_stop;
    chk("R4 scan pre", scan_mode, 3);
    bus_start;
    send_byte(8'h6C, a);
    send_byte(8'h90, a); chk("R5 ack", a, 1);
    bus_stop;
    chk("R5 ref_sel loaded", ref_sel, 1);
    chk("R5 ext_clk loaded", ext_clk, 0);
    chk("R5 scan default", scan_mode, 0);
    chk("R5 chan default", chan_sel, 0);
    chk("R5 single default", single_ended, 1);
  endtask

  task automatic t_mismatch;
    logic a;
    bus_start;
    send_byte(8'h50, a); chk("R3 no addr ack", a, 0);
    send_byte(8'h63, a); chk("R3 no data ack", a, 0);
    bus_stop;
    chk("R3 scan kept", scan_mode, 0);
    chk("R3 single kept", single_ended, 1);
  endtask

  task automatic t_read;
    logic a;
    int r0;
    r0 = rd_cnt;
    bus_start;
    send_byte(8'h6D, a); chk("R8 read ack", a, 1);
    chk("R8 rd pulse", rd_cnt - r0, 1);
    send_byte(8'h63, a); chk("R8 released", a, 0);
    bus_stop;
    chk("R8 cfg ignored", scan_mode, 0);
  endtask

  task automatic t_hs;
    logic a;
    bus_start;
    send_byte(8'h0D, a); chk("R6 nack", a, 0);
    chk("R6 hs set", hs_mode, 1);
    bus_rstart;
    chk("R9 hs kept", hs_mode, 1);
    send_byte(8'h6C, a); chk("R9 addr after sr", a, 1);
    send_byte(8'h21, a); chk("R9 data ack", a, 1);
    chk("R9 hs still", hs_mode, 1);
    bus_stop;
    chk("R7 hs cleared", hs_mode, 0);
    chk("R9 scan", scan_mode, 1);
    chk("R9 single", single_ended, 1);
  endtask

  initial begin
    fork
      begin
        qw(5); rst_n = 1; qw(5);
        t_reset;
        t_write_both_orders;
        t_cfg_reset;
        t_mismatch;
        t_read;
        t_hs;
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule